// File: doc/BRIEF.md
# Vectored Interrupt Controller with Stack Guard

This block arbitrates and acknowledges interrupts for a small 8-bit processor core. It has three sources: a time-base tick, a timer 0 overflow and a timer 1 overflow. Each source has a sticky request flag and its own enable. A single global enable gates all three sources. All of these bits sit in one 8-bit control register that software reads and writes.

Requests latch whenever their event pulses. They are evaluated only on a sampling-phase pulse from the core. A request is acknowledged when its flag and enable are set, the global enable is set, and the core reports that its return stack has room. On acknowledge, the block gives the core a one-cycle push request with a fixed vector address. In the same update it clears the serviced flag and the global enable. The core reports which return kind it executed: a return-from-interrupt sets the global enable again, and a plain return leaves it unchanged. Software can set the global enable and a source enable inside a service routine to allow nesting.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `ctl_rd` reads 0x00 and `irq_take` is 0.
- R2: Register layout of `ctl_rd` and `ctl_wdata`. Bit 0 is the global enable. Bits 1, 2 and 3 are the enables for time base, timer 0 and timer 1. Bits 4, 5 and 6 are the request flags for the same three sources. Bit 7 always reads 0. A write with `ctl_we` loads bits 0 to 6, and they can be read on the next cycle.
- R3: An event pulse on `src_evt` (bit 0 time base, bit 1 timer 0, bit 2 timer 1) sets the matching flag on the next clock edge, even when the global enable is 0. The flag stays set until it is serviced or written to 0.
- R4: An acknowledge happens only on an edge where `smp_pulse` is 1 and the global enable is 1. At least one source must also have both its flag and its enable set. `irq_take` is then 1 for exactly the cycle after that edge.
- R5: `irq_vec` is 0x04 for time base, 0x08 for timer 0 and 0x0C for timer 1. It is valid while `irq_take` is 1.
- R6: When several enabled requests are pending at the same time, time base wins over timer 0, and timer 0 wins over timer 1.
- R7: An acknowledge clears the serviced flag and the global enable in the same update. All other flags and all enables are left unchanged. The global enable clear has priority over a software write and over `ret_irq` in the same cycle.
- R8: While `stk_full` is 1, no acknowledge happens. The request stays pending and is taken on a later sampling pulse after `stk_full` has dropped.
- R9: `ret_irq` sets the global enable. `ret_plain` leaves it unchanged. A software write of bit 0 has priority over `ret_irq`.
- R10: If an event arrives in the same cycle as a software write that clears its flag, or as an acknowledge that clears it, the flag ends up set.
- R11: Requests that arrive between sampling pulses are not acknowledged until the next pulse. At that pulse they are arbitrated together.
- R12: If software sets the global enable again inside a service routine, a further pending enabled request is acknowledged on the next sampling pulse. The stack rule still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 3 | Event pulses: bit 0 time base, bit 1 timer 0, bit 2 timer 1 |
| smp_pulse | input | 1 | Sampling-phase pulse; arbitration is done only on edges where it is 1 |
| stk_full | input | 1 | Return stack full; blocks acknowledge |
| ret_irq | input | 1 | Return-from-interrupt executed |
| ret_plain | input | 1 | Plain return executed |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rd | output | 8 | Control register read value |
| irq_take | output | 1 | One-cycle push request to the core |
| irq_vec | output | 12 | Vector address of the acknowledged source |

## Verification
The bench targets the following corner cases.

- **Simultaneous requests.** A design with the wrong priority would return vector 0x08 or 0x0C while the time-base flag is pending.
- **Full stack.** A missing stack guard would push onto a full stack. A design that drops the request instead of holding it would never return the vector after `stk_full` falls.
- **Return kinds.** If `ret_plain` were treated like `ret_irq`, the global enable would turn on and cause an unexpected second acknowledge.
- **Event colliding with a clear.** When an event meets a software clear or an acknowledge clear in the same cycle, a design that lets the clear win would lose the event. That shows up as a missing flag in the readback.
- **Requests between pulses.** A design that arbitrates without `smp_pulse` would acknowledge too early.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_NSRC     = 3;
  localparam int unsigned IRQ_REG_W    = 8;
  localparam int unsigned IRQ_GIE_BIT  = 0;
  localparam int unsigned IRQ_EN_LSB   = 1;
  localparam int unsigned IRQ_FLG_LSB  = IRQ_EN_LSB + IRQ_NSRC;
  localparam int unsigned IRQ_VEC_STEP = 4;
  localparam int unsigned IRQ_IDX_W    = (IRQ_NSRC > 1) ? $clog2(IRQ_NSRC) : 1;

  typedef logic [IRQ_NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IRQ_REG_W-1:0] wr_data,
  input  src_vec_t             evt,
  input  logic                 ack,
  input  src_vec_t             ack_mask,
  input  logic                 ret_irq,
  output logic                 gie,
  output src_vec_t             en,
  output src_vec_t             flag,
  output logic [IRQ_REG_W-1:0] rd_data
);
  logic     gie_q, gie_d;
  src_vec_t en_q, en_d;
  src_vec_t flag_q, flag_d;
  src_vec_t flag_base;
  logic     upd;

  // next state: ack clear applied after write, event set applied last (R10)
  always_comb begin
    flag_base = wr_en ? wr_data[IRQ_FLG_LSB +: IRQ_NSRC] : flag_q;
    flag_d    = (flag_base & ~(ack ? ack_mask : '0)) | evt;
    en_d      = wr_en ? wr_data[IRQ_EN_LSB +: IRQ_NSRC] : en_q;
    if (ack)          gie_d = 1'b0;
    else if (wr_en)   gie_d = wr_data[IRQ_GIE_BIT];
    else if (ret_irq) gie_d = 1'b1;
    else              gie_d = gie_q;
    upd = wr_en | ack | ret_irq | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else if (upd) begin
      gie_q  <= gie_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data                           = '0;
    rd_data[IRQ_GIE_BIT]              = gie_q;
    rd_data[IRQ_EN_LSB +: IRQ_NSRC]   = en_q;
    rd_data[IRQ_FLG_LSB +: IRQ_NSRC]  = flag_q;
  end

  assign gie  = gie_q;
  assign en   = en_q;
  assign flag = flag_q;

  // R3: an event always leaves its flag set after the edge
  for (genvar s = 0; s < IRQ_NSRC; s++) begin : g_evt_chk
    a_r3_evt_latches: assert property (@(posedge clk) disable iff (!rst_n)
      evt[s] |=> flag_q[s]);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 3,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end
  assign any = blocked[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp,
  input  logic              stk_full,
  input  logic              gie,
  input  src_vec_t          pend,
  output logic              ack,
  output src_vec_t          ack_mask,
  output logic              take,
  output logic [ADDR_W-1:0] vec
);
  src_vec_t               grant;
  logic [IRQ_IDX_W-1:0]   idx;
  logic                   any;
  logic                   take_d;
  logic [ADDR_W-1:0]      vec_q, vec_d;

  irq_prio_pick #(.N(IRQ_NSRC), .IDX_W(IRQ_IDX_W)) u_pick (
    .req   (pend),
    .grant (grant),
    .idx   (idx),
    .any   (any)
  );

  always_comb begin
    ack      = smp & gie & ~stk_full & any;
    ack_mask = grant;
    take_d   = ack;
    vec_d    = ADDR_W'((32'(idx) + 32'd1) * IRQ_VEC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take  <= 1'b0;
      vec_q <= '0;
    end else begin
      take <= take_d;
      if (ack) vec_q <= vec_d;
    end
  end

  assign vec = vec_q;

  // R8: a full stack on the sampling edge never yields a push
  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |=> !take);
  // R11: no push without a sampling pulse
  a_r11_only_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> !take);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_NSRC-1:0]  src_evt,
  input  logic                 smp_pulse,
  input  logic                 stk_full,
  input  logic                 ret_irq,
  input  logic                 ret_plain,
  input  logic                 ctl_we,
  input  logic [IRQ_REG_W-1:0] ctl_wdata,
  output logic [IRQ_REG_W-1:0] ctl_rd,
  output logic                 irq_take,
  output logic [ADDR_W-1:0]    irq_vec
);
  logic     gie, ack;
  src_vec_t en, flag, ack_mask, pend;

  irq_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_we),
    .wr_data  (ctl_wdata),
    .evt      (src_evt),
    .ack      (ack),
    .ack_mask (ack_mask),
    .ret_irq  (ret_irq),
    .gie      (gie),
    .en       (en),
    .flag     (flag),
    .rd_data  (ctl_rd)
  );

  assign pend = en & flag;

  irq_ack_unit #(.ADDR_W(ADDR_W)) u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (smp_pulse),
    .stk_full (stk_full),
    .gie      (gie),
    .pend     (pend),
    .ack      (ack),
    .ack_mask (ack_mask),
    .take     (irq_take),
    .vec      (irq_vec)
  );

  // R4: a push needs global enable set on the sampling edge
  a_r4_take_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(ctl_rd[IRQ_GIE_BIT]) && $past(smp_pulse));
  // R7: global enable reads 0 right after a push
  a_r7_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> !ctl_rd[IRQ_GIE_BIT]);
  // R5: vector is one of the three fixed entries
  a_r5_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_vec == ADDR_W'(4) || irq_vec == ADDR_W'(8) || irq_vec == ADDR_W'(12)));
  // R6: timer vectors never win over a pending enabled time base request
  a_r6_tb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_vec != ADDR_W'(4)) |-> !($past(ctl_rd[IRQ_FLG_LSB]) && $past(ctl_rd[IRQ_EN_LSB])));
  // R9: plain return alone leaves global enable unchanged
  a_r9_plain_ret_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_plain && !ret_irq && !ctl_we && !ack) |=> ctl_rd[IRQ_GIE_BIT] == $past(ctl_rd[IRQ_GIE_BIT]));
  // R9: return-from-interrupt sets global enable when nothing overrides it
  a_r9_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_irq && !ctl_we && !ack) |=> ctl_rd[IRQ_GIE_BIT]);
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  src_evt;
  logic        smp_pulse, stk_full, ret_irq, ret_plain, ctl_we;
  logic [7:0]  ctl_wdata;
  logic [7:0]  ctl_rd;
  logic        irq_take;
  logic [11:0] irq_vec;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  m_reg;
  logic        m_take;
  logic [11:0] m_vec;

  always #4 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .smp_pulse(smp_pulse),
    .stk_full(stk_full), .ret_irq(ret_irq), .ret_plain(ret_plain),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd),
    .irq_take(irq_take), .irq_vec(irq_vec)
  );

  // expected next register value from R2, R3, R7, R9, R10
  function automatic logic [7:0] exp_next_reg(input logic [7:0] r, input logic [2:0] ev,
      input logic smp, input logic sf, input logic we, input logic [7:0] wd, input logic ri);
    logic [2:0] pend, fl, en, sel;
    logic ack, g;
    pend = r[6:4] & r[3:1];
    ack  = smp & r[0] & ~sf & (|pend);
    sel  = pend[0] ? 3'b001 : pend[1] ? 3'b010 : pend[2] ? 3'b100 : 3'b000;
    fl   = we ? wd[6:4] : r[6:4];
    if (ack) fl = fl & ~sel;
    fl   = fl | ev;
    en   = we ? wd[3:1] : r[3:1];
    g    = ack ? 1'b0 : we ? wd[0] : ri ? 1'b1 : r[0];
    return {1'b0, fl, en, g};
  endfunction

  // expected push and vector from R4, R5, R6, R8, R11
  function automatic logic [12:0] exp_push(input logic [7:0] r, input logic smp, input logic sf);
    logic [2:0] pend;
    pend = r[6:4] & r[3:1];
    if (!(smp & r[0] & ~sf & (|pend))) return 13'd0;
    if (pend[0]) return {1'b1, 12'h004};
    if (pend[1]) return {1'b1, 12'h008};
    return {1'b1, 12'h00C};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, step the model, compare at next negedge
  task automatic cyc(input string tag, input logic [2:0] ev, input logic smp, input logic sf,
      input logic we, input logic [7:0] wd, input logic ri, input logic rp);
    logic [12:0] p;
    src_evt = ev; smp_pulse = smp; stk_full = sf; ctl_we = we;
    ctl_wdata = wd; ret_irq = ri; ret_plain = rp;
    p      = exp_push(m_reg, smp, sf);
    m_reg  = exp_next_reg(m_reg, ev, smp, sf, we, wd, ri);
    m_take = p[12];
    if (p[12]) m_vec = p[11:0];
    @(negedge clk);
    check({tag, " reg"}, 32'(ctl_rd), 32'(m_reg));
    check({tag, " take"}, 32'(irq_take), 32'(m_take));
    if (m_take) check({tag, " vec"}, 32'(irq_vec), 32'(m_vec));
  endtask

  task automatic idle(input string tag);
    cyc(tag, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic wr(input string tag, input logic [7:0] d);
    cyc(tag, 3'b000, 1'b0, 1'b0, 1'b1, d, 1'b0, 1'b0);
  endtask

  task automatic smp(input string tag, input logic sf);
    cyc(tag, 3'b000, 1'b1, sf, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20230917));
    rst_n = 1'b0; src_evt = '0; smp_pulse = 0; stk_full = 0; ret_irq = 0;
    ret_plain = 0; ctl_we = 0; ctl_wdata = '0;
    m_reg = '0; m_take = 0; m_vec = '0;
    repeat (3) @(negedge clk);
    check("R1 reset reg", 32'(ctl_rd), 32'h0);
    check("R1 reset take", 32'(irq_take), 32'h0);
    rst_n = 1'b1;
    idle("R1 after release");

    wr("R2 write all ones", 8'hFF);                  // bit 7 reads 0
    wr("R2 write pattern", 8'h2A);
    wr("R2 clear", 8'h00);

    cyc("R3 tb event gie off", 3'b001, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    idle("R3 flag holds");
    smp("R4 no take gie off", 1'b0);

    wr("R11 enable all", 8'h0F);                      // flags cleared by write
    cyc("R11 t1 event", 3'b100, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    cyc("R11 tb event", 3'b001, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    idle("R11 no pulse no take");
    smp("R6 tb wins", 1'b0);
    idle("R7 after take");
    cyc("R9 plain return", 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    smp("R9 plain keeps gie off", 1'b0);
    cyc("R9 reti sets gie", 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);

    smp("R8 blocked by full", 1'b1);
    smp("R8 still blocked", 1'b1);
    idle("R8 pending kept");
    smp("R8 taken after drop", 1'b0);               // vector 0x0C

    wr("R6 all flags", 8'h7F);
    smp("R6 tb first", 1'b0);
    wr("R12 nest gie on", 8'h6F);
    smp("R12 nested t0", 1'b0);
    wr("R12 nest again", 8'h4F);
    smp("R12 nested t1", 1'b0);

    wr("R10 setup t0 flag", 8'h20);
    cyc("R10 event vs sw clear", 3'b010, 1'b0, 1'b0, 1'b1, 8'h05, 1'b0, 1'b0);
    cyc("R10 event vs ack clear", 3'b010, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    cyc("R7 ack beats write", 3'b000, 1'b0, 1'b0, 1'b1, 8'h25, 1'b1, 1'b0);
    cyc("R7 ack beats write edge", 3'b000, 1'b1, 1'b0, 1'b1, 8'h25, 1'b1, 1'b0);
    idle("R5 vector hold");

    for (int k = 0; k < 4000; k++) begin
      logic [2:0] ev;
      logic s, f, w, ri, rp;
      logic [7:0] d;
      ev = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      s  = ($urandom % 3) == 0;
      f  = ($urandom % 4) == 0;
      w  = ($urandom % 6) == 0;
      d  = 8'($urandom);
      ri = ($urandom % 8) == 0;
      rp = ($urandom % 8) == 0;
      cyc("R4 random", ev, s, f, w, d, ri, rp);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule